// File: doc/BRIEF.md
# Perpendicular Recording Mode Configuration Register

This block keeps the perpendicular-recording setup of a floppy disk controller that serves several drives. A command byte, already separated out of the command stream by the controller's parser, is loaded through a one-cycle write strobe. The byte carries two global mode bits (a gap-select bit and a write-gate-select bit), one perpendicular flag per drive, and an enable bit. The per-drive flags are replaced only when that enable bit is set.

The block continuously resolves the recording mode for the drive that is currently selected and the data rate that is currently programmed. It reports that mode as one of three codes: conventional, perpendicular at the lower rate, or perpendicular at 1 Mbps. The code is registered so that the Gap2 length and the read-sync timers that use it see a stable value. Next to the mode, the block passes on the write precompensation code that applies. A perpendicular drive always gets zero, and a conventional drive gets the programmed value.

Two resets act on the block. The asynchronous hardware reset clears everything. The synchronous soft reset, raised by the controller's software-reset paths, clears only the two global bits and keeps the per-drive flags.

Top module: `pmode_cfg`

## Requirements
- R1: While the active-low hardware reset is asserted, the global bits and all drive flags are cleared. After release, every drive resolves to conventional mode (code 2'b00), and precomp_out follows precomp_in.
- R2: On a strobed write with cmd_byte bit 7 at 1, drive n's flag is loaded from cmd_byte bit 2+n. With bit 7 at 0 the flags keep their values, while bit 1 (gap-select) and bit 0 (write-gate-select) are still loaded.
- R3: When both global bits are 0, a selected drive whose flag is 1 resolves to a perpendicular code and one whose flag is 0 resolves to 2'b00. Code 2'b11 never appears.
- R4: When both global bits are 1, every drive resolves to 2'b10 (1 Mbps perpendicular), whatever its flag and the data rate.
- R5: When write-gate-select is 1 and gap-select is 0, every drive resolves to 2'b01 (lower-rate perpendicular), whatever its flag and the data rate.
- R6: When gap-select is 1 and write-gate-select is 0, every drive resolves to 2'b00, whatever its flag.
- R7: A drive made perpendicular by its own flag resolves to 2'b10 when rate_sel is 2'b11 (1 Mbps) and to 2'b01 for any other rate_sel value.
- R8: precomp_out is 0 whenever mode_out is not 2'b00, and equals precomp_in when mode_out is 2'b00.
- R9: A soft_rst pulse clears both global bits and leaves every drive flag unchanged.
- R10: A write strobed in the same cycle as soft_rst is discarded entirely.
- R11: mode_out and precomp_out reflect the state and inputs of the previous clock edge: a change of drv_sel shows on the outputs after exactly one rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| soft_rst | input | 1 | Synchronous soft reset pulse |
| cmd_wr | input | 1 | Write strobe for cmd_byte |
| cmd_byte | input | 8 | Command byte: bit 7 flag enable, bits 2+n drive flags, bit 1 gap-select, bit 0 write-gate-select |
| drv_sel | input | 2 | Currently selected drive |
| rate_sel | input | 2 | Programmed data rate, 2'b11 = 1 Mbps |
| precomp_in | input | 3 | Programmed write precompensation code |
| mode_out | output | 2 | Registered recording mode: 00 conventional, 01 lower-rate perpendicular, 10 1 Mbps perpendicular |
| precomp_out | output | 3 | Registered precompensation code to apply |

## Verification
The bench goes after the flag-enable bit. A write with the bit clear must still take the global bits while leaving the flags alone; a design that gated the whole write, or none of it, would show the wrong mode on a later drive selection. It checks that the global bits override the flags in all three non-zero combinations, including gap-select alone. A design that let the flags through there would report a perpendicular code for a flagged drive. It also separates the two resets: a soft reset that also cleared the flags, or a write that slipped past a simultaneous soft reset, shows up as a wrong mode for a flagged drive afterwards. Finally, the one-edge output latency and the zeroed precompensation for perpendicular drives are sampled on the exact edge.

// File: rtl/pmode_pkg.sv
package pmode_pkg;

   // resolved recording mode, consumed by the Gap2 and sync timers
   typedef enum logic [1:0] {
      PM_CONV    = 2'b00,
      PM_PERP_LO = 2'b01,
      PM_PERP_HI = 2'b10
   } pmode_e;

   localparam int CMD_W     = 8;
   localparam int BIT_WGSEL = 0;
   localparam int BIT_GPSEL = 1;
   localparam int BIT_FLAG0 = 2;
   localparam int BIT_FLEN  = 7;
   localparam int MAX_DRV   = BIT_FLEN - BIT_FLAG0;

   localparam logic [1:0] RATE_TOP = 2'b11;

endpackage

// File: rtl/pmode_cmd_regs.sv
module pmode_cmd_regs
   import pmode_pkg::*;
#(
   parameter int NUM_DRIVES = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  soft_rst,
   input  logic                  cmd_wr,
   input  logic [CMD_W-1:0]      cmd_byte,
   output logic                  gpsel_q,
   output logic                  wgsel_q,
   output logic [NUM_DRIVES-1:0] flags_q
);

   logic take_cmd;
   logic take_flags;

   // a soft reset in the same cycle swallows the write
   assign take_cmd   = cmd_wr && !soft_rst;
   assign take_flags = take_cmd && cmd_byte[BIT_FLEN];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gpsel_q <= 1'b0;
         wgsel_q <= 1'b0;
      end else if (soft_rst) begin
         gpsel_q <= 1'b0;
         wgsel_q <= 1'b0;
      end else if (take_cmd) begin
         gpsel_q <= cmd_byte[BIT_GPSEL];
         wgsel_q <= cmd_byte[BIT_WGSEL];
      end
   end

   // one flag register per drive, cleared only by the hardware reset
   for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flags_q[d] <= 1'b0;
         end else if (take_flags) begin
            flags_q[d] <= cmd_byte[BIT_FLAG0 + d];
         end
      end
   end

   AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && !cmd_byte[BIT_FLEN]) |=> $stable(flags_q)) else $error("flags moved without enable"); // R2

   AST_SOFT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (!gpsel_q && !wgsel_q && $stable(flags_q))) else $error("soft reset effect wrong"); // R9

   AST_SOFT_BEATS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (soft_rst && cmd_wr) |=> (!gpsel_q && !wgsel_q)) else $error("write passed soft reset"); // R10

endmodule

// File: rtl/pmode_resolve.sv
module pmode_resolve
   import pmode_pkg::*;
#(
   parameter int NUM_DRIVES = 4,
   parameter int SEL_W      = 2,
   parameter int PRE_W      = 3
) (
   input  logic                  gpsel,
   input  logic                  wgsel,
   input  logic [NUM_DRIVES-1:0] flags,
   input  logic [SEL_W-1:0]      drv_sel,
   input  logic [1:0]            rate_sel,
   input  logic [PRE_W-1:0]      precomp_in,
   output pmode_e                mode_nxt,
   output logic [PRE_W-1:0]      precomp_nxt
);

   logic sel_flag;

   // an out-of-range selection reads as a conventional drive
   always_comb begin
      sel_flag = 1'b0;
      for (int d = 0; d < NUM_DRIVES; d++) begin
         if (drv_sel == SEL_W'(d)) sel_flag = flags[d];
      end
   end

   always_comb begin
      unique case ({wgsel, gpsel})
         2'b11:   mode_nxt = PM_PERP_HI;
         2'b10:   mode_nxt = PM_PERP_LO;
         2'b01:   mode_nxt = PM_CONV;
         default: begin
            if (!sel_flag)                mode_nxt = PM_CONV;
            else if (rate_sel == RATE_TOP) mode_nxt = PM_PERP_HI;
            else                          mode_nxt = PM_PERP_LO;
         end
      endcase
   end

   assign precomp_nxt = (mode_nxt == PM_CONV) ? precomp_in : '0;

endmodule

// File: rtl/pmode_out_stage.sv
module pmode_out_stage
   import pmode_pkg::*;
#(
   parameter int PRE_W   = 3,
   parameter bit OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  pmode_e           mode_nxt,
   input  logic [PRE_W-1:0] precomp_nxt,
   output pmode_e           mode_q,
   output logic [PRE_W-1:0] precomp_q
);

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mode_q    <= PM_CONV;
            precomp_q <= '0;
         end else begin
            mode_q    <= mode_nxt;
            precomp_q <= precomp_nxt;
         end
      end
   end else begin : g_thru
      assign mode_q    = mode_nxt;
      assign precomp_q = precomp_nxt;
   end

endmodule

// File: rtl/pmode_cfg.sv
module pmode_cfg
   import pmode_pkg::*;
#(
   parameter int NUM_DRIVES = 4,
   parameter int PRECOMP_W  = 3,
   parameter bit OUT_REG    = 1'b1,
   localparam int SEL_W     = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 soft_rst,
   input  logic                 cmd_wr,
   input  logic [7:0]           cmd_byte,
   input  logic [SEL_W-1:0]     drv_sel,
   input  logic [1:0]           rate_sel,
   input  logic [PRECOMP_W-1:0] precomp_in,
   output logic [1:0]           mode_out,
   output logic [PRECOMP_W-1:0] precomp_out
);

   if (NUM_DRIVES < 1 || NUM_DRIVES > MAX_DRV) begin : g_bad_drives
      $error("NUM_DRIVES must fit the flag field of the command byte");
   end
   if (PRECOMP_W < 1) begin : g_bad_precomp
      $error("PRECOMP_W must be at least 1");
   end

   logic                  gpsel_q;
   logic                  wgsel_q;
   logic [NUM_DRIVES-1:0] flags_q;
   pmode_e                mode_nxt;
   pmode_e                mode_q;
   logic [PRECOMP_W-1:0]  precomp_nxt;

   pmode_cmd_regs #(.NUM_DRIVES(NUM_DRIVES)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (soft_rst),
      .cmd_wr   (cmd_wr),
      .cmd_byte (cmd_byte),
      .gpsel_q  (gpsel_q),
      .wgsel_q  (wgsel_q),
      .flags_q  (flags_q)
   );

   pmode_resolve #(
      .NUM_DRIVES (NUM_DRIVES),
      .SEL_W      (SEL_W),
      .PRE_W      (PRECOMP_W)
   ) u_resolve (
      .gpsel       (gpsel_q),
      .wgsel       (wgsel_q),
      .flags       (flags_q),
      .drv_sel     (drv_sel),
      .rate_sel    (rate_sel),
      .precomp_in  (precomp_in),
      .mode_nxt    (mode_nxt),
      .precomp_nxt (precomp_nxt)
   );

   pmode_out_stage #(
      .PRE_W   (PRECOMP_W),
      .OUT_REG (OUT_REG)
   ) u_out (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_nxt    (mode_nxt),
      .precomp_nxt (precomp_nxt),
      .mode_q      (mode_q),
      .precomp_q   (precomp_out)
   );

   assign mode_out = mode_q;

   AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      mode_out != 2'b11) else $error("illegal mode code"); // R3

   AST_PRECOMP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_out != PM_CONV) |-> (precomp_out == '0)) else $error("precomp not zero"); // R8

   if (OUT_REG) begin : g_reg_checks
      AST_GLOBAL_HI: assert property (@(posedge clk) disable iff (!rst_n)
         (gpsel_q && wgsel_q) |=> (mode_out == PM_PERP_HI)) else $error("global hi override"); // R4

      AST_GLOBAL_LO: assert property (@(posedge clk) disable iff (!rst_n)
         (wgsel_q && !gpsel_q) |=> (mode_out == PM_PERP_LO)) else $error("global lo override"); // R5

      AST_GAP_ONLY_CONV: assert property (@(posedge clk) disable iff (!rst_n)
         (gpsel_q && !wgsel_q) |=> (mode_out == PM_CONV)) else $error("gap-only not conv"); // R6
   end

endmodule

// File: tb/pmode_cfg_test.sv
`timescale 1ns/100ps
module pmode_cfg_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       soft_rst = 1'b0;
   logic       cmd_wr = 1'b0;
   logic [7:0] cmd_byte = 8'h00;
   logic [1:0] drv_sel = 2'd0;
   logic [1:0] rate_sel = 2'b00;
   logic [2:0] precomp_in = 3'd0;
   logic [1:0] mode_out;
   logic [2:0] precomp_out;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pmode_cfg uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .soft_rst    (soft_rst),
      .cmd_wr      (cmd_wr),
      .cmd_byte    (cmd_byte),
      .drv_sel     (drv_sel),
      .rate_sel    (rate_sel),
      .precomp_in  (precomp_in),
      .mode_out    (mode_out),
      .precomp_out (precomp_out)
   );

   localparam logic [1:0] CONV = 2'b00;
   localparam logic [1:0] PLO  = 2'b01;
   localparam logic [1:0] PHI  = 2'b10;

   // {wr, cmd, drv, rate, precomp, exp_mode, exp_precomp, req}
   localparam int NV = 12;
   localparam logic [28:0] VEC [NV] = '{
      {1'b1, 8'h98, 2'd1, 2'b00, 3'd5, PLO,  3'd0, 8'd7},  // R7 flags d1,d2 loaded
      {1'b0, 8'h00, 2'd0, 2'b00, 3'd5, CONV, 3'd5, 8'd3},  // R3 unflagged drive
      {1'b0, 8'h00, 2'd2, 2'b11, 3'd4, PHI,  3'd0, 8'd7},  // R7 flagged at 1 Mbps
      {1'b0, 8'h00, 2'd3, 2'b01, 3'd6, CONV, 3'd6, 8'd3},  // R3
      {1'b1, 8'h3C, 2'd0, 2'b00, 3'd2, CONV, 3'd2, 8'd2},  // R2 enable clear
      {1'b0, 8'h00, 2'd1, 2'b10, 3'd2, PLO,  3'd0, 8'd2},  // R2 d1 kept
      {1'b1, 8'h03, 2'd0, 2'b00, 3'd7, PHI,  3'd0, 8'd4},  // R4
      {1'b0, 8'h00, 2'd3, 2'b01, 3'd7, PHI,  3'd0, 8'd4},  // R4
      {1'b1, 8'h01, 2'd2, 2'b11, 3'd3, PLO,  3'd0, 8'd5},  // R5 flag and rate ignored
      {1'b1, 8'h02, 2'd1, 2'b00, 3'd3, CONV, 3'd3, 8'd6},  // R6 flag ignored
      {1'b1, 8'h84, 2'd0, 2'b11, 3'd1, PHI,  3'd0, 8'd8},  // R8 precomp zeroed
      {1'b0, 8'h00, 2'd1, 2'b11, 3'd1, CONV, 3'd1, 8'd2}   // R2 d1 cleared
   };

   task automatic check(input int req, input logic [1:0] am, input logic [1:0] em,
                        input logic [2:0] ap, input logic [2:0] ep);
      n_checks++;
      if (am !== em || ap !== ep) begin
         n_errors++;
         $display("FAIL R%0d: mode=%b precomp=%0d expected mode=%b precomp=%0d",
                  req, am, ap, em, ep);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic apply(input logic wr, input logic [7:0] cmd, input logic [1:0] drv,
                        input logic [1:0] rate, input logic [2:0] pre);
      cmd_wr = wr; cmd_byte = cmd; drv_sel = drv; rate_sel = rate; precomp_in = pre;
      tick();
      cmd_wr = 1'b0;
      tick();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state while held and after release
      precomp_in = 3'd6;
      check(1, mode_out, CONV, precomp_out, 3'd0);
      rst_n = 1'b1;
      tick();
      tick();
      check(1, mode_out, CONV, precomp_out, 3'd6);

      for (int i = 0; i < NV; i++) begin
         apply(VEC[i][28], VEC[i][27:20], VEC[i][19:18], VEC[i][17:16], VEC[i][15:13]);
         check(int'(VEC[i][7:0]), mode_out, VEC[i][12:11], precomp_out, VEC[i][10:8]);
      end

      // R9: soft reset keeps flags, clears globals
      apply(1'b1, 8'h93, 2'd0, 2'b00, 3'd4);
      check(4, mode_out, PHI, precomp_out, 3'd0);
      soft_rst = 1'b1;
      tick();
      soft_rst = 1'b0;
      tick();
      check(9, mode_out, CONV, precomp_out, 3'd4);
      apply(1'b0, 8'h00, 2'd2, 2'b00, 3'd4);
      check(9, mode_out, PLO, precomp_out, 3'd0);

      // R10: write during soft reset is dropped
      cmd_wr = 1'b1; cmd_byte = 8'h81; soft_rst = 1'b1;
      tick();
      cmd_wr = 1'b0; soft_rst = 1'b0;
      tick();
      check(10, mode_out, PLO, precomp_out, 3'd0);
      apply(1'b0, 8'h00, 2'd0, 2'b01, 3'd5);
      check(10, mode_out, CONV, precomp_out, 3'd5);

      // R11: one edge of latency on a selection change
      drv_sel = 2'd2;
      #1;
      check(11, mode_out, CONV, precomp_out, 3'd5);
      tick();
      check(11, mode_out, PLO, precomp_out, 3'd0);

      // R1: hardware reset clears the drive flags
      rst_n = 1'b0;
      tick();
      rst_n = 1'b1;
      tick();
      tick();
      check(1, mode_out, CONV, precomp_out, 3'd5);

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      done = 1'b1;
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

endmodule